// File: doc/BRIEF.md
# Table-Driven Next-State Sequencer

This block is a sequencer whose state register never increments by itself. On each enabled clock it loads a code read from a constant lookup table. The table is addressed by the current state with a small external select vector joined above it. One datapath can therefore step through jumps, non-monotonic orders and input-dependent branches. A second constant table maps each state to an output word. That word is registered on the same edge as the state, so equal outputs can come from distinct states.

The table contents are computed at elaboration from a profile parameter. No memory file is involved and the tables cannot be written at run time. Two profiles are built in:
- a jump counter that skips a gap in the code space;
- a six-state pattern generator with a two-way branch on select bit 0.

In both profiles every code outside the legal cycle maps back to state 0, so the machine cannot lock up. No data moves as a stream here, so every pin is a plain control or status signal with no handshake.

Top module: `seqr_rom_sequencer`

## Requirements
- R1: While synchronous reset `rst` is high at a rising clock edge, `state` becomes 0 and `out_word` becomes the output decode of state 0, which is 0 in both profiles.
- R2: With `en` low at an edge, `state` and `out_word` keep their values whatever `sel_in` carries.
- R3: With `en` high at an edge, `state` loads the table word addressed by `{sel_in, state}`, with the select vector in the upper address bits and the state in the lower bits.
- R4: In the pattern profile (PROFILE=1) with `sel_in[0]` low, the states run 0,1,2,3,4,5 and back to 0, with outputs 0,1,1,3,2,2 in that order.
- R5: In the pattern profile with `sel_in[0]` high, state 2 goes to 4 and state 4 goes to 1. States 0, 1, 3 and 5 step as in R4.
- R6: In the jump profile (PROFILE=0) the states run 0 to 6, then load 10, run 10 to 15, and wrap to 0. Here the output is the low two bits of the state and `sel_in` has no effect.
- R7: Any code outside the legal cycle goes to state 0, with output 0, after one enabled edge. The outside codes are 6 to 15 in the pattern profile and 7, 8 and 9 in the jump profile.
- R8: `out_word` always shows the output decode of the value `state` holds at that time, because both registers update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds state and output |
| sel_in | input | IN_W (2) | External select, upper part of table address |
| state | output | STATE_W (4) | Current state register |
| out_word | output | OUT_W (2) | Registered output decode of the current state |

## Verification
The assertions assume that the state register changes only at clock edges. They also assume reset is applied before the first check. The bench breaks the first assumption on purpose when it plants an illegal code with a force. It always does this directly after a reset cycle, so every assertion attempt that spans the forced change is disabled. Inputs are changed shortly after the falling edge and are held stable across each rising edge. No input is ever left unknown after reset.

// File: rtl/seqr_pkg.sv
`timescale 1ns/1ps
package seqr_pkg;

  localparam int PROF_JUMP    = 0;
  localparam int PROF_PATTERN = 1;

  // successor of a code; sel is the select vector value, only bit 0 matters
  function automatic int next_code(int prof, int sel, int code);
    int r;
    r = 0;
    if (prof == PROF_PATTERN) begin
      if ((sel % 2) == 1 && code == 2)      r = 4;
      else if ((sel % 2) == 1 && code == 4) r = 1;
      else if (code <= 4)                   r = code + 1;
      else                                  r = 0;
    end else begin
      if (code <= 5)                     r = code + 1;
      else if (code == 6)                r = 10;
      else if (code >= 10 && code <= 14) r = code + 1;
      else                               r = 0;
    end
    return r;
  endfunction

  function automatic int out_code(int prof, int code);
    int r;
    r = 0;
    if (prof == PROF_PATTERN) begin
      case (code)
        1, 2:    r = 1;
        3:       r = 3;
        4, 5:    r = 2;
        default: r = 0;
      endcase
    end else begin
      r = code % 4;
    end
    return r;
  endfunction

  function automatic bit legal_code(int prof, int code);
    if (prof == PROF_PATTERN) return code <= 5;
    return (code <= 6) || (code >= 10);
  endfunction

endpackage

// File: rtl/seqr_table.sv
`timescale 1ns/1ps
module seqr_table #(
  parameter int STATE_W = 4,
  parameter int IN_W    = 2,
  parameter int OUT_W   = 2,
  parameter int PROFILE = 1
) (
  input  logic [IN_W-1:0]    sel,
  input  logic [STATE_W-1:0] cur,
  output logic [STATE_W-1:0] nxt,
  output logic [OUT_W-1:0]   nxt_out
);
  localparam int ADDR_W = IN_W + STATE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CODES  = 1 << STATE_W;

  logic [STATE_W-1:0] next_rom [DEPTH];
  logic [OUT_W-1:0]   out_rom  [CODES];
  logic [ADDR_W-1:0]  addr;

  // successor table, one entry per {select, state} pair
  for (genvar a = 0; a < DEPTH; a++) begin : g_next
    assign next_rom[a] = STATE_W'(seqr_pkg::next_code(PROFILE, a / CODES, a % CODES));
  end

  // output decode, one entry per state code
  for (genvar c = 0; c < CODES; c++) begin : g_out
    assign out_rom[c] = OUT_W'(seqr_pkg::out_code(PROFILE, c));
  end

  assign addr    = {sel, cur};
  assign nxt     = next_rom[addr];
  assign nxt_out = out_rom[nxt];

endmodule

// File: rtl/seqr_state_reg.sv
`timescale 1ns/1ps
module seqr_state_reg #(
  parameter int               STATE_W = 4,
  parameter int               OUT_W   = 2,
  parameter logic [OUT_W-1:0] RST_OUT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [STATE_W-1:0] load_code,
  input  logic [OUT_W-1:0]   load_out,
  output logic [STATE_W-1:0] state_q,
  output logic [OUT_W-1:0]   out_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      out_q   <= RST_OUT;
    end else if (en) begin
      state_q <= load_code;
      out_q   <= load_out;
    end
  end

  // R2: a disabled edge changes nothing
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(state_q) && $stable(out_q)));

  // R3: an enabled edge takes the table word
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> state_q == $past(load_code));

  // R8: the output register tracks the decode of the loaded code
  p_out_follows_r8: assert property (@(posedge clk) disable iff (rst)
    en |=> out_q == $past(load_out));

endmodule

// File: rtl/seqr_rom_sequencer.sv
`timescale 1ns/1ps
module seqr_rom_sequencer #(
  parameter int STATE_W = 4,
  parameter int IN_W    = 2,
  parameter int OUT_W   = 2,
  parameter int PROFILE = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [IN_W-1:0]    sel_in,
  output logic [STATE_W-1:0] state,
  output logic [OUT_W-1:0]   out_word
);
  localparam logic [OUT_W-1:0] RST_OUT = OUT_W'(seqr_pkg::out_code(PROFILE, 0));

  logic [STATE_W-1:0] nxt;
  logic [OUT_W-1:0]   nxt_out;

  seqr_table #(
    .STATE_W(STATE_W), .IN_W(IN_W), .OUT_W(OUT_W), .PROFILE(PROFILE)
  ) u_table (
    .sel(sel_in), .cur(state), .nxt(nxt), .nxt_out(nxt_out)
  );

  seqr_state_reg #(
    .STATE_W(STATE_W), .OUT_W(OUT_W), .RST_OUT(RST_OUT)
  ) u_reg (
    .clk(clk), .rst(rst), .en(en),
    .load_code(nxt), .load_out(nxt_out),
    .state_q(state), .out_q(out_word)
  );

  // R7: an outside code returns to 0 after one enabled edge
  p_recover_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !seqr_pkg::legal_code(PROFILE, int'(state))) |=> state == '0);

  // R4 / R6: a legal code never leads outside the cycle
  p_stay_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (en && seqr_pkg::legal_code(PROFILE, int'(state)))
      |=> seqr_pkg::legal_code(PROFILE, int'(state)));

endmodule

// File: tb/seqr_rom_sequencer_test.sv
`timescale 1ns/1ps
module seqr_rom_sequencer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [3:0] st_p, st_j;
  logic [1:0] ow_p, ow_j;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  seqr_rom_sequencer #(.PROFILE(1)) uut (
    .clk(clk), .rst(rst), .en(en), .sel_in(sel), .state(st_p), .out_word(ow_p));

  seqr_rom_sequencer #(.PROFILE(0)) uut_jump (
    .clk(clk), .rst(rst), .en(en), .sel_in(sel), .state(st_j), .out_word(ow_j));

  typedef struct {
    logic [3:0] sp; logic [1:0] op;
    logic [3:0] sj; logic [1:0] oj;
    int tag;
  } item_t;

  item_t q[$];
  logic [3:0] mp = 4'd0;
  logic [3:0] mj = 4'd0;

  // bench model of the pattern profile (R4, R5)
  function automatic logic [3:0] pat_next(logic b, logic [3:0] s);
    case (s)
      4'd0: return 4'd1;
      4'd1: return 4'd2;
      4'd2: return b ? 4'd4 : 4'd3;
      4'd3: return 4'd4;
      4'd4: return b ? 4'd1 : 4'd5;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [1:0] pat_out(logic [3:0] s);
    logic [1:0] lut [6] = '{2'd0, 2'd1, 2'd1, 2'd3, 2'd2, 2'd2};
    return (s < 6) ? lut[s] : 2'd0;
  endfunction

  // bench model of the jump profile (R6)
  function automatic logic [3:0] jmp_next(logic [3:0] s);
    if (s == 4'd6) return 4'd10;
    if (s == 4'd15) return 4'd0;
    if (s < 4'd6 || s >= 4'd10) return s + 4'd1;
    return 4'd0;
  endfunction

  task automatic check(string what, int tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check("pattern state", it.tag, int'(st_p), int'(it.sp));
      check("pattern out",   it.tag, int'(ow_p), int'(it.op));
      check("jump state",    it.tag, int'(st_j), int'(it.sj));
      check("jump out",      it.tag, int'(ow_j), int'(it.oj));
    end
  end

  task automatic push(int tag);
    item_t it;
    it.sp = mp; it.op = pat_out(mp);
    it.sj = mj; it.oj = mj[1:0];
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(logic e, logic [1:0] s, int tag);
    @(negedge clk); #1;
    en = e; sel = s;
    if (e) begin
      mp = pat_next(s[0], mp);
      mj = jmp_next(mj);
    end
    push(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1; en = 1'b1; sel = 2'b11;
    @(negedge clk);
    // R1: reset state and output
    check("reset pattern state", 1, int'(st_p), 0);
    check("reset pattern out",   1, int'(ow_p), 0);
    check("reset jump state",    1, int'(st_j), 0);
    check("reset jump out",      1, int'(ow_j), 0);
    #1; rst = 1'b0; en = 1'b0;
    mp = 4'd0; mj = 4'd0;
  endtask

  // R7: plant an outside code right after a reset cycle
  task automatic inject(logic [3:0] cp, logic [3:0] cj);
    @(negedge clk); #1;
    rst = 1'b1;
    @(negedge clk); #1;
    rst = 1'b0; en = 1'b1; sel = 2'b01;
    force uut.u_reg.state_q = cp;
    force uut_jump.u_reg.state_q = cj;
    #0.1;
    release uut.u_reg.state_q;
    release uut_jump.u_reg.state_q;
    mp = 4'd0; mj = 4'd0;
    push(7);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R4 and R6: plain run, select low, full cycles of both profiles
    for (int i = 0; i < 16; i++) step(1'b1, 2'b00, 4);
    // R2: hold with select wiggling
    for (int i = 0; i < 4; i++) step(1'b0, 2'(i), 2);
    // R5: branching with select bit 0 high
    for (int i = 0; i < 10; i++) step(1'b1, 2'b01, 5);
    // R3: select bit 1 toggles, mixed enable
    for (int i = 0; i < 12; i++) step(1'(i % 3 != 2), 2'(i), 3);
    // R6: continue the jump profile across its wrap
    for (int i = 0; i < 14; i++) step(1'b1, 2'b10, 6);
    // R7: each outside code once
    for (int k = 0; k < 10; k++) inject(4'(6 + k), 4'(7 + (k % 3)));
    step(1'b1, 2'b00, 8);
    step(1'b1, 2'b00, 8);
    // R1: reset in mid-run
    do_reset();
    step(1'b1, 2'b00, 8);
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule